// File: doc/BRIEF.md
# NAND Bad-Block Table Scanner

After reset this block walks every erase block of a NAND array once, in ascending order. For each block it asks a flash sequencer for one byte, the marker byte, from the first page and then from the second page of the block. A block is recorded as bad when a marker byte that comes back is anything other than the erased value FFh. When page 0 already shows a mark, the read of page 1 is skipped. Block 0 is never read and never recorded, because that block is guaranteed good.

The result is a one-bit-per-block map held in flops. A combinational port looks up any block in the map. A running count of bad blocks is kept, and an error flag rises once the count exceeds the guaranteed bad-block budget. While the scan runs, and after it ends, a mark input lets runtime code add a block that failed program or erase to the same map.

The read port is a simple request/acknowledge pair with a separate response strobe, so the sequencer may take any number of cycles to accept a request and to answer it.

Top module: `bbt_scanner`

## Requirements
- R1: While reset is held and just after it is released: `scan_done` is 0, `bad_count` is 0, `dev_error` is 0, and `lk_bad` is 0 for every block.
- R2: Requests go out in ascending block order, from block 1 to NUM_BLOCKS-1. Each block is read at page 0 and then at page 1, always at column MARK_COL. A request (`rd_req` high) holds its block, page and column unchanged until the cycle in which `rd_ready` is high.
- R3: A response byte other than FFh for either checked page sets the block's bit in the map (1 = bad). FFh on both pages leaves the bit at 0.
- R4: When a block's page-0 byte is not FFh, the next request is for page 0 of the following block. No page-1 read is issued for that block.
- R5: Block 0 is never requested and its bit stays 0. A mark on block 0 has no effect on the map or on the count.
- R6: `lk_bad` shows the map bit of `lk_block` combinationally, in the same cycle. A bit that a response or a mark sets at a clock edge is visible right after that edge.
- R7: `bad_count` equals the number of distinct blocks whose bit is 1. Marking a block that is already bad does not change it.
- R8: `dev_error` is 1 exactly when `bad_count` is greater than MAX_BAD.
- R9: `scan_done` rises on the edge that accepts the last response for block NUM_BLOCKS-1 and then stays high. No request is issued after it.
- R10: A `mark_valid` pulse sets the bit of `mark_block` at the next edge, both during the scan and after it.
- R11: A `rsp_valid` that arrives while no request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the scan starts when reset is released |
| rd_req | output | 1 | Byte-read request valid |
| rd_ready | input | 1 | Sequencer accepts the request this cycle |
| rd_block | output | BLK_W | Block index of the request |
| rd_page | output | PAGE_W | Page within the block (0 or 1) |
| rd_col | output | COL_W | Column of the marker byte |
| rsp_valid | input | 1 | Response byte valid |
| rsp_data | input | 8 | Response byte |
| mark_valid | input | 1 | Runtime mark-bad strobe |
| mark_block | input | BLK_W | Block to mark bad |
| lk_block | input | BLK_W | Lookup index |
| lk_bad | output | 1 | Map bit of `lk_block` (1 = bad) |
| bad_count | output | CNT_W | Number of bad blocks recorded |
| dev_error | output | 1 | Bad-block count exceeds MAX_BAD |
| scan_done | output | 1 | Scan complete |

## Verification
The bench builds the block with NUM_BLOCKS = 32, MAX_BAD = 3 and MARK_COL = 517. With these values a full scan takes a few hundred cycles, and the error threshold is crossed by a handful of marked blocks. The flash model places marks on page 0 only, on page 1 only, and on both pages, and one mark differs from FFh in a single bit. The sequencer stalls and delays with a varying pattern and sends stray responses. Runtime marks land on block 0, on a fresh block during the scan, and on already-bad and fresh blocks after the scan.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
   typedef enum logic [1:0] {
      WK_REQ  = 2'd0,
      WK_WAIT = 2'd1,
      WK_DONE = 2'd2
   } walk_st_e;

   localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/bbt_walker.sv
module bbt_walker
   import bbt_pkg::*;
#(
   parameter int NUM_BLOCKS  = 512,
   parameter int BLK_W       = 9,
   parameter int PAGE_W      = 4,
   parameter int COL_W       = 10,
   parameter int MARK_COL    = 0,
   parameter bit CHECK_PAGE1 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   input  logic              rd_ready,
   output logic [BLK_W-1:0]  rd_block,
   output logic [PAGE_W-1:0] rd_page,
   output logic [COL_W-1:0]  rd_col,
   input  logic              rsp_valid,
   input  logic [7:0]        rsp_data,
   output logic              scan_set,
   output logic [BLK_W-1:0]  scan_blk,
   output logic              done
);
   localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

   walk_st_e          st_q;
   logic [BLK_W-1:0]  blk_q;
   logic [PAGE_W-1:0] pg_q;
   logic              rsp_take;
   logic              byte_bad;
   logic              want_page1;

   assign rsp_take = (st_q == WK_WAIT) && rsp_valid;
   assign byte_bad = (rsp_data != ERASED_BYTE);

   generate
      if (CHECK_PAGE1) begin : g_two_pages
         assign want_page1 = (pg_q == '0);
      end else begin : g_one_page
         assign want_page1 = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= WK_REQ;
         blk_q <= BLK_W'(1);
         pg_q  <= '0;
      end else begin
         case (st_q)
            WK_REQ: if (rd_ready) st_q <= WK_WAIT;
            WK_WAIT: if (rsp_valid) begin
               if (!byte_bad && want_page1) begin
                  pg_q <= PAGE_W'(1);
                  st_q <= WK_REQ;
               end else if (blk_q == LAST_BLK) begin
                  st_q <= WK_DONE;
               end else begin
                  blk_q <= blk_q + BLK_W'(1);
                  pg_q  <= '0;
                  st_q  <= WK_REQ;
               end
            end
            default: st_q <= WK_DONE;
         endcase
      end
   end

   assign rd_req   = (st_q == WK_REQ);
   assign rd_block = blk_q;
   assign rd_page  = pg_q;
   assign rd_col   = COL_W'(MARK_COL);
   assign scan_set = rsp_take && byte_bad;
   assign scan_blk = blk_q;
   assign done     = (st_q == WK_DONE);

   // R2: request holds until accepted
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ready |=> rd_req && $stable(rd_block) && $stable(rd_page));
   // R4: a failed page 0 moves on to page 0 of the next block
   p_skip_page1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      scan_set && (rd_page == '0) |=> (rd_page == '0));
   // R5: block 0 is never read
   p_never_blk0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_block != '0));
   // R9: done is sticky and silences requests
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done && !rd_req);
endmodule

// File: rtl/bbt_bitmap.sv
module bbt_bitmap #(
   parameter int NUM_BLOCKS = 512,
   parameter int BLK_W      = 9,
   parameter int CNT_W      = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_set,
   input  logic [BLK_W-1:0] scan_blk,
   input  logic             mark_valid,
   input  logic [BLK_W-1:0] mark_block,
   input  logic [BLK_W-1:0] lk_block,
   output logic             lk_bad,
   output logic [CNT_W-1:0] bad_count
);
   logic [NUM_BLOCKS-1:0] bad_q;
   logic [NUM_BLOCKS-1:0] scan_hot;
   logic [NUM_BLOCKS-1:0] mark_hot;
   logic                  mark_ok;
   logic                  scan_new;
   logic                  mark_new;
   logic [CNT_W-1:0]      cnt_q;

   assign mark_ok  = mark_valid && (mark_block != '0);
   assign scan_hot = scan_set ? (NUM_BLOCKS'(1) << scan_blk) : '0;
   assign mark_hot = mark_ok ? (NUM_BLOCKS'(1) << mark_block) : '0;

   // a bit counts only the first time it is set; a shared target counts once
   assign scan_new = scan_set && !bad_q[scan_blk];
   assign mark_new = mark_ok && !bad_q[mark_block] &&
                     !(scan_set && (scan_blk == mark_block));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bad_q <= '0;
         cnt_q <= '0;
      end else begin
         bad_q <= bad_q | scan_hot | mark_hot;
         cnt_q <= cnt_q + CNT_W'(scan_new) + CNT_W'(mark_new);
      end
   end

   assign lk_bad    = bad_q[lk_block];
   assign bad_count = cnt_q;

   // R5: block 0 is never recorded as bad
   p_blk0_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q[0] == 1'b0);
   // R7: the count never decreases and grows by at most two per edge
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q >= $past(cnt_q)) && (cnt_q - $past(cnt_q) <= CNT_W'(2)));
   // R10: a recorded bad block stays recorded
   p_map_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((bad_q & $past(bad_q)) == $past(bad_q)));
   // R7: the count never exceeds the number of markable blocks
   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(NUM_BLOCKS - 1));
endmodule

// File: rtl/bbt_scanner.sv
module bbt_scanner #(
   parameter int NUM_BLOCKS      = 512,
   parameter int PAGES_PER_BLOCK = 16,
   parameter int PAGE_BYTES      = 528,
   parameter int MARK_COL        = 0,
   parameter int MAX_BAD         = 10,
   parameter bit CHECK_PAGE1     = 1'b1,
   localparam int BLK_W  = $clog2(NUM_BLOCKS),
   localparam int PAGE_W = $clog2(PAGES_PER_BLOCK),
   localparam int COL_W  = $clog2(PAGE_BYTES),
   localparam int CNT_W  = $clog2(NUM_BLOCKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   input  logic              rd_ready,
   output logic [BLK_W-1:0]  rd_block,
   output logic [PAGE_W-1:0] rd_page,
   output logic [COL_W-1:0]  rd_col,
   input  logic              rsp_valid,
   input  logic [7:0]        rsp_data,
   input  logic              mark_valid,
   input  logic [BLK_W-1:0]  mark_block,
   input  logic [BLK_W-1:0]  lk_block,
   output logic              lk_bad,
   output logic [CNT_W-1:0]  bad_count,
   output logic              dev_error,
   output logic              scan_done
);
   generate
      if (NUM_BLOCKS < 2 || (1 << BLK_W) != NUM_BLOCKS) begin : g_bad_blocks
         $error("NUM_BLOCKS must be a power of two of at least 2");
      end
      if (PAGES_PER_BLOCK < 2 || (1 << PAGE_W) != PAGES_PER_BLOCK) begin : g_bad_pages
         $error("PAGES_PER_BLOCK must be a power of two of at least 2");
      end
      if (MARK_COL < 0 || MARK_COL >= PAGE_BYTES) begin : g_bad_col
         $error("MARK_COL must lie inside the page");
      end
      if (MAX_BAD < 0 || MAX_BAD >= NUM_BLOCKS) begin : g_bad_max
         $error("MAX_BAD must be below NUM_BLOCKS");
      end
   endgenerate

   logic             scan_set;
   logic [BLK_W-1:0] scan_blk;

   bbt_walker #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .BLK_W      (BLK_W),
      .PAGE_W     (PAGE_W),
      .COL_W      (COL_W),
      .MARK_COL   (MARK_COL),
      .CHECK_PAGE1(CHECK_PAGE1)
   ) u_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .rd_ready (rd_ready),
      .rd_block (rd_block),
      .rd_page  (rd_page),
      .rd_col   (rd_col),
      .rsp_valid(rsp_valid),
      .rsp_data (rsp_data),
      .scan_set (scan_set),
      .scan_blk (scan_blk),
      .done     (scan_done)
   );

   bbt_bitmap #(
      .NUM_BLOCKS(NUM_BLOCKS),
      .BLK_W     (BLK_W),
      .CNT_W     (CNT_W)
   ) u_bitmap (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_set  (scan_set),
      .scan_blk  (scan_blk),
      .mark_valid(mark_valid),
      .mark_block(mark_block),
      .lk_block  (lk_block),
      .lk_bad    (lk_bad),
      .bad_count (bad_count)
   );

   assign dev_error = (bad_count > CNT_W'(MAX_BAD));

   // R8: once over budget, the error stays (the count only grows)
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dev_error |=> dev_error);
   // R9: no response is taken after the scan has finished
   p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_set);
endmodule

// File: tb/bbt_scanner_bench.sv
module bbt_scanner_bench;
   localparam int NB      = 32;
   localparam int MAXB    = 3;
   localparam int MCOL    = 517;
   localparam int BLK_W   = $clog2(NB);
   localparam int LIMIT   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_req, rd_ready = 1'b0;
   logic [BLK_W-1:0] rd_block;
   logic [3:0] rd_page;
   logic [9:0] rd_col;
   logic       rsp_valid = 1'b0;
   logic [7:0] rsp_data = 8'hFF;
   logic       mark_valid = 1'b0;
   logic [BLK_W-1:0] mark_block = '0;
   logic [BLK_W-1:0] lk_block = '0;
   logic       lk_bad;
   logic [5:0] bad_count;
   logic       dev_error, scan_done;

   always #4 clk = ~clk;

   bbt_scanner #(.NUM_BLOCKS(NB), .MARK_COL(MCOL), .MAX_BAD(MAXB)) u_bbt_scanner (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ready(rd_ready),
      .rd_block(rd_block), .rd_page(rd_page), .rd_col(rd_col),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mark_valid(mark_valid),
      .mark_block(mark_block), .lk_block(lk_block), .lk_bad(lk_bad),
      .bad_count(bad_count), .dev_error(dev_error), .scan_done(scan_done));

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // flash content: marker byte for (block, page)
   function automatic logic [7:0] flash_byte(int b, int p);
      if (p == 0 && (b == 3 || b == 24)) return 8'h00;
      if (p == 0 && b == 10)             return 8'hFE;
      if (p == 1 && (b == 5 || b == 24 || b == 27)) return 8'h00;
      return 8'hFF;
   endfunction

   // reference model
   int  m_phase;       // 0 requesting, 1 awaiting response, 2 finished
   int  m_blk, m_pg, m_cnt, lat;
   bit  m_map [NB];
   int  done_cyc;

   task automatic model_set(int b);
      if (b != 0 && !m_map[b]) begin
         m_map[b] = 1'b1;
         m_cnt++;
      end
   endtask

   task automatic lookup_chk(int b, bit exp, string tag);
      lk_block = BLK_W'(b);
      #1;
      chk(lk_bad == exp, tag, lk_bad, exp);
   endtask

   initial begin
      bit saw_p1_of_3;
      saw_p1_of_3 = 1'b0;
      m_phase = 0; m_blk = 1; m_pg = 0; m_cnt = 0; lat = 0; done_cyc = -1;
      foreach (m_map[i]) m_map[i] = 1'b0;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(scan_done == 1'b0, "R1 scan_done in reset", scan_done, 0);
      chk(bad_count == 0, "R1 bad_count in reset", bad_count, 0);
      chk(dev_error == 1'b0, "R1 dev_error in reset", dev_error, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bad_count == 0 && !scan_done, "R1 state after release", bad_count, 0);
      for (int b = 0; b < NB; b++) lookup_chk(b, 1'b0, "R1 map clear");

      for (int cyc = 0; cyc < LIMIT; cyc++) begin
         if (cyc > 0) @(negedge clk);
         // compare on every clock
         chk(rd_req == (m_phase == 0), "R2 rd_req", rd_req, m_phase == 0);
         if (m_phase == 0) begin
            chk(rd_block == BLK_W'(m_blk), "R2 rd_block", rd_block, m_blk);
            chk(rd_page == 4'(m_pg), "R2 rd_page", rd_page, m_pg);
            chk(rd_col == 10'(MCOL), "R2 rd_col", rd_col, MCOL);
            if (rd_block == 3 && rd_page == 1) saw_p1_of_3 = 1'b1;
         end
         chk(scan_done == (m_phase == 2), "R9 scan_done", scan_done, m_phase == 2);
         chk(bad_count == 6'(m_cnt), "R7 bad_count", bad_count, m_cnt);
         chk(dev_error == (m_cnt > MAXB), "R8 dev_error", dev_error, m_cnt > MAXB);
         lookup_chk(cyc % NB, m_map[cyc % NB], "R6 lookup");

         if (m_phase == 2 && done_cyc < 0) done_cyc = cyc;
         if (done_cyc >= 0 && cyc > done_cyc + 10) break;

         // drive inputs for the coming edge
         rd_ready   = (m_phase == 0) ? (cyc % 3 != 0) : 1'b1;
         rsp_valid  = 1'b0;
         rsp_data   = 8'hFF;
         mark_valid = 1'b0;
         if (m_phase == 1) begin
            if (lat == 0) begin
               rsp_valid = 1'b1;
               rsp_data  = flash_byte(m_blk, m_pg);
            end else lat--;
         end else if (m_phase == 0 && cyc % 9 == 0) begin
            rsp_valid = 1'b1;          // R11: stray response, no request outstanding
            rsp_data  = 8'h00;
         end
         if (cyc == 20) begin mark_valid = 1'b1; mark_block = '0; end       // R5
         if (cyc == 40) begin mark_valid = 1'b1; mark_block = BLK_W'(12); end // R10
         if (done_cyc >= 0 && cyc == done_cyc + 2) begin mark_valid = 1'b1; mark_block = BLK_W'(5); end
         if (done_cyc >= 0 && cyc == done_cyc + 4) begin mark_valid = 1'b1; mark_block = BLK_W'(30); end

         // model the edge
         if (mark_valid) model_set(int'(mark_block));
         case (m_phase)
            0: if (rd_ready) begin m_phase = 1; lat = cyc % 4; end
            1: if (rsp_valid) begin
               bit bad;
               bad = (rsp_data != 8'hFF);
               if (bad) model_set(m_blk);
               if (!bad && m_pg == 0) begin
                  m_pg = 1; m_phase = 0;
               end else if (m_blk == NB - 1) begin
                  m_phase = 2;
               end else begin
                  m_blk++; m_pg = 0; m_phase = 0;
               end
            end
            default: ;
         endcase
      end

      if (done_cyc < 0) chk(1'b0, "R9 watchdog expired before scan_done", 0, 1);
      @(negedge clk);
      chk(!saw_p1_of_3, "R4 page 1 of block 3 not read", saw_p1_of_3, 0);
      lookup_chk(0, 1'b0, "R5 block 0 valid after mark");
      lookup_chk(3, 1'b1, "R3 page-0 mark");
      lookup_chk(10, 1'b1, "R3 single-bit mark FEh");
      lookup_chk(27, 1'b1, "R3 page-1 mark");
      lookup_chk(4, 1'b0, "R3 erased block valid");
      lookup_chk(12, 1'b1, "R10 mark during scan");
      lookup_chk(30, 1'b1, "R10 mark after scan");
      chk(bad_count == 7, "R7 final count", bad_count, 7);
      chk(dev_error == 1'b1, "R8 over budget", dev_error, 1);
      chk(scan_done == 1'b1 && !rd_req, "R9 finished and quiet", scan_done, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule